// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block adds two unsigned operands and a carry-in in a single combinational step. It returns the sum and a carry-out. The operand bits are divided into groups whose widths grow from the least significant end. At the default width of 16 the groups are 2, 2, 3, 4 and 5 bits wide. The lowest group is a plain ripple adder fed by the external carry-in. Every higher group builds a single ripple result that assumes its carry-in is zero. An incrementer one bit wider than the group adds one to the concatenation of that result's carry and sum, which gives the carry-in-one candidate without a second ripple adder. The carry arriving from the group below then chooses between the two candidates.

The group partition is computed from the `WIDTH` parameter by a package function. Group 0 is 2 bits wide and group k above it is k+1 bits wide. Any bits left over that are too few to start a new group are added to the topmost group. With this rule a width of 8 gives groups of 2, 2 and 4 bits.

The adder is intended to sit in a datapath stage where a fast, moderately small adder is needed, with registers placed around it by the surrounding logic.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the unsigned sum a + b + cin computed with a width of WIDTH+1 bits.
- R2: At WIDTH=16 the groups are 2, 2, 3, 4 and 5 bits wide from the least significant end, so group boundaries sit at bits 2, 4, 7 and 11. A carry produced below a boundary enters the group above it. With a set to all ones below a boundary, b=1 and cin=0, the result is sum = 1 shifted left by the boundary position and cout = 0.
- R3: The lowest group adds the external carry-in. With a=0, b=0 and cin=1 the result is sum=1 and cout=0.
- R4: When the carry into an upper group is 0, that group outputs its carry-in-zero ripple result unchanged. With a=16'hFFFC, b=0 and cin=0 the result is sum=16'hFFFC and cout=0.
- R5: When the carry into an upper group is 1, that group outputs its incremented result. With a=16'h0003, b=16'h0001 and cin=0 the result is sum=16'h0004 and cout=0.
- R6: The incrementer wraps: when a group's carry-in-zero result is all ones and its incoming carry is 1, the group outputs all zeros and sends out a carry. With a=16'hFFFF, b=0 and cin=1 the result is sum=0 and cout=1. With a=b=16'hFFFF and cin=1 the result is sum=16'hFFFF and cout=1.
- R7: With zero operands and cin=0 the result is sum=0 and cout=0.
- R8: At WIDTH=8 the partition is 2, 2 and 4 bits, and {cout, sum} equals a + b + cin computed with 9 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The bound checker checks the whole result against arithmetic addition on every input change (R1). It also checks each inter-group carry against the carry of the matching prefix sum (R2), the lowest sum bit against the external carry-in (R3), the zero case (R7) and the wrap case (R6). Which candidate each upper group selects is visible only through the values chosen by the bench. Directed vectors hold the incoming carry at 0 with saturated upper groups (R4), force a carry across each boundary (R2, R5) and wrap every group together (R6). A second instance at width 8 exercises the partition rule for the remainder (R8), and random vectors cover the general case.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int BASE_GROUP_W = 2;

    typedef struct packed {
        logic s;
        logic c;
    } bit_res_t;

    function automatic bit_res_t half_add(input logic x, input logic y);
        bit_res_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

    function automatic bit_res_t full_add(input logic x, input logic y, input logic ci);
        bit_res_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

    // Number of groups: 2 bits, then 2, 3, 4, ... while the remaining bits allow.
    function automatic int num_groups(input int width);
        int used;
        int nxt;
        int n;
        used = (width < BASE_GROUP_W) ? width : BASE_GROUP_W;
        n    = 1;
        nxt  = BASE_GROUP_W;
        while ((width - used) >= nxt) begin
            used += nxt;
            n++;
            nxt++;
        end
        return n;
    endfunction

    // Width of group idx; bits too few for a new group join the top group.
    function automatic int grp_width(input int width, input int idx);
        int n;
        int base;
        int used;
        n    = num_groups(width);
        used = 0;
        for (int k = 0; k < n; k++) begin
            base = (k == 0) ? BASE_GROUP_W : k + 1;
            if (k == n - 1) base = width - used;
            if (k == idx) return base;
            used += base;
        end
        return 0;
    endfunction

    // Least significant bit of group idx; idx equal to the group count gives width.
    function automatic int grp_lsb(input int width, input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += grp_width(width, k);
        return acc;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int N       = 2,
    parameter bit USE_CIN = 1'b0
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    logic [N:1] cy;

    generate
        if (USE_CIN) begin : g_bit0_full
            csa_pkg::bit_res_t r0;
            assign r0     = csa_pkg::full_add(a[0], b[0], cin);
            assign sum[0] = r0.s;
            assign cy[1]  = r0.c;
        end else begin : g_bit0_half
            csa_pkg::bit_res_t r0;
            logic unused_cin;
            assign unused_cin = cin;
            assign r0     = csa_pkg::half_add(a[0], b[0]);
            assign sum[0] = r0.s;
            assign cy[1]  = r0.c;
        end

        for (genvar i = 1; i < N; i++) begin : g_bit
            csa_pkg::bit_res_t r;
            assign r       = csa_pkg::full_add(a[i], b[i], cy[i]);
            assign sum[i]  = r.s;
            assign cy[i+1] = r.c;
        end
    endgenerate

    assign cout = cy[N];
endmodule

// File: rtl/csa_incr.sv
module csa_incr #(
    parameter int N = 3
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] all_low;

    assign all_low[0] = din[0];
    assign dout[0]    = ~din[0];

    generate
        for (genvar i = 1; i < N; i++) begin : g_bit
            assign dout[i]    = din[i] ^ all_low[i-1];
            assign all_low[i] = all_low[i-1] & din[i];
        end
    endgenerate

    logic unused_top;
    assign unused_top = all_low[N-1];
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sel,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int EW = N + 1;

    logic [N-1:0]  s_zero;
    logic          c_zero;
    logic [EW-1:0] plain;
    logic [EW-1:0] bumped;

    csa_ripple #(.N(N), .USE_CIN(1'b0)) u_ripple (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .sum  (s_zero),
        .cout (c_zero)
    );

    assign plain = {c_zero, s_zero};

    csa_incr #(.N(EW)) u_incr (
        .din  (plain),
        .dout (bumped)
    );

    assign {cout, sum} = sel ? bumped : plain;
endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NG  = csa_pkg::num_groups(WIDTH);
    localparam int GW0 = csa_pkg::grp_width(WIDTH, 0);

    logic [NG:0] grp_carry;

    assign grp_carry[0] = cin;

    csa_ripple #(.N(GW0), .USE_CIN(1'b1)) u_low (
        .a    (a[GW0-1:0]),
        .b    (b[GW0-1:0]),
        .cin  (grp_carry[0]),
        .sum  (sum[GW0-1:0]),
        .cout (grp_carry[1])
    );

    generate
        for (genvar g = 1; g < NG; g++) begin : g_grp
            localparam int GW  = csa_pkg::grp_width(WIDTH, g);
            localparam int LSB = csa_pkg::grp_lsb(WIDTH, g);
            csa_group #(.N(GW)) u_grp (
                .a    (a[LSB +: GW]),
                .b    (b[LSB +: GW]),
                .sel  (grp_carry[g]),
                .sum  (sum[LSB +: GW]),
                .cout (grp_carry[g+1])
            );
        end
    endgenerate

    assign cout = grp_carry[NG];
endmodule

// File: rtl/csa_sqrt_adder_chk.sv
module csa_sqrt_adder_chk #(
    parameter int WIDTH = 16,
    parameter int NG    = 5
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [NG:0]      grp_carry
);
    function automatic logic prefix_carry(input logic [WIDTH-1:0] x,
                                          input logic [WIDTH-1:0] y,
                                          input logic ci, input int e);
        logic [WIDTH:0] t;
        logic [WIDTH-1:0] m;
        m = {WIDTH{1'b1}} >> (WIDTH - e);
        t = {1'b0, x & m} + {1'b0, y & m} + {{WIDTH{1'b0}}, ci};
        return t[e];
    endfunction

    always_comb begin
        AST_SUM_EXACT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("sum mismatch"); // R1
        AST_LOW_CIN: assert (sum[0] == (a[0] ^ b[0] ^ cin))
            else $error("low bit ignores cin"); // R3
        if (a == '0 && b == '0 && !cin) begin
            AST_ZERO_RESULT: assert (sum == '0 && !cout)
                else $error("zero case"); // R7
        end
        if (&a && b == '0 && cin) begin
            AST_WRAP_ALL: assert (sum == '0 && cout)
                else $error("wrap case"); // R6
        end
        for (int g = 1; g <= NG; g++) begin
            AST_GROUP_CARRY: assert (grp_carry[g] == prefix_carry(a, b, cin, csa_pkg::grp_lsb(WIDTH, g)))
                else $error("group carry %0d", g); // R2
        end
    end
endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk #(
    .WIDTH (WIDTH),
    .NG    (NG)
) u_chk (
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .grp_carry (grp_carry)
);

// File: tb/csa_sqrt_adder_tb.sv
module csa_sqrt_adder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int W8 = 8;

    typedef struct {
        logic [W:0]  exp16;
        logic [W8:0] exp8;
        string       tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic [W8-1:0] sum8;
    logic          cout8;

    item_t sb_q[$];
    item_t it;
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csa_sqrt_adder #(.WIDTH(W)) u_dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    csa_sqrt_adder #(.WIDTH(W8)) u_dut8 (
        .a(a[W8-1:0]), .b(b[W8-1:0]), .cin(cin), .sum(sum8), .cout(cout8)
    );

    task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string tag);
        item_t e;
        @(posedge clk);
        a   = va;
        b   = vb;
        cin = vc;
        e.exp16 = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        e.exp8  = {1'b0, va[W8-1:0]} + {1'b0, vb[W8-1:0]} + {{W8{1'b0}}, vc};
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops expectations at the falling edge after they were driven.
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_cmp++;
            if ({cout, sum} !== it.exp16) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, {cout, sum}, it.exp16);
            end
            n_cmp++;
            if ({cout8, sum8} !== it.exp8) begin
                n_bad++;
                $display("FAIL R8 (8-bit, %s): actual=%h expected=%h", it.tag, {cout8, sum8}, it.exp8);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1: actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        drive(16'h0000, 16'h0000, 1'b0, "R7 zero operands");
        drive(16'h0000, 16'h0000, 1'b1, "R3 external carry-in");
        drive(16'h0003, 16'h0001, 1'b0, "R5 carry into group 1");
        drive(16'hFFFC, 16'h0000, 1'b0, "R4 incoming carry zero");
        drive(16'hFFFF, 16'h0000, 1'b1, "R6 wrap all groups");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones plus carry");
        drive(16'h0003, 16'h0000, 1'b1, "R2 boundary 2");
        drive(16'h000F, 16'h0001, 1'b0, "R2 boundary 4");
        drive(16'h007F, 16'h0001, 1'b0, "R2 boundary 7");
        drive(16'h07FF, 16'h0001, 1'b0, "R2 boundary 11");
        drive(16'h8000, 16'h8000, 1'b0, "R1 top carry only");
        drive(16'h00FF, 16'h0001, 1'b0, "R8 carry out of 8-bit");
        drive(16'h1234, 16'h4321, 1'b0, "R1 no carries");
        drive(16'hAAAA, 16'h5555, 1'b1, "R1 alternating with carry");
        for (int i = 0; i < 1500; i++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        end

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        report();
    end
endmodule